// File: doc/BRIEF.md
# ISA Bus Cycle Generator

This block is the host-side master of an ISA expansion bus. An internal agent hands it one request at a time: a memory access, an I/O access or a refresh, with a direction, a 24-bit address, a flag that asks for a 16-bit transfer and a flag that marks the access as a DMA transfer. The block turns the request into a full bus cycle. It presents the address and strobes the address latch for one clock. It then holds a single command strobe for a programmable minimum number of clocks and stretches it for as long as the addressed slave holds channel-ready low. A recovery clock with every strobe released closes the cycle.

The block picks the transfer width from the slave's response. When a 16-bit request reaches a slave that does not answer with the chip-select matching the access type, the block runs two 8-bit cycles in place of one. A strap input selects whether the low sixteen address pins are dedicated to the bus or shared with a secondary disk data path. In shared mode the block drives a transceiver enable so that the bus address appears only while a cycle is in progress.

Top module: `isa_cycle_gen`

## Requirements
- R1: While reset is held and after it is released, the four command strobes and both below-1 MB strobes are high, the latch strobe, address enable and done are low, the transceiver enable is high and ready is high.
- R2: An accepted request produces one clock of address-latch strobe, followed one clock later by its command strobe. The system address stays stable while the command strobe is low.
- R3: At most one of the I/O read, I/O write, memory read and memory write strobes is low in any clock. Request kind encoding: 0 memory, 1 I/O, 2 or 3 refresh. A refresh uses the memory read strobe.
- R4: The below-1 MB read and write strobes follow the memory read and write strobes only when address bits 23:20 are all zero. Otherwise they stay high.
- R5: The system address pins carry address bits 19:0 and the latched address pins carry bits 23:17 of the access in progress.
- R6: The command strobe stays low for CMD_MIN clocks (default 4). If channel-ready is low at an edge where the strobe is low, the strobe is still low in the next clock. With ready low for the first W clocks of the command, the strobe lasts max(CMD_MIN, W+1) clocks.
- R7: A 16-bit request runs as one cycle, with byte-high-enable low during the command, when the I/O 16-bit select (for I/O) or the memory 16-bit select (for memory) is low during the latch clock. The select belonging to the other access type has no effect.
- R8: A 16-bit request that gets no matching select runs as two 8-bit cycles. The first uses the even address with byte-high-enable high. The second uses the address with bit 0 set and byte-high-enable low.
- R9: Byte-high-enable is high throughout a refresh cycle, even when the refresh address is odd. For an 8-bit access it is low exactly when address bit 0 is set.
- R10: Address enable is high from the latch clock through the recovery clock of a DMA-flagged request and low for all other requests.
- R11: With the shared strap high, the transceiver enable is low from the latch clock through the recovery clock of every cycle and high when idle. With the strap low, it stays high.
- R12: Ready is high only when idle. A request presented while busy is ignored. Done pulses for one clock in the recovery clock of the last cycle of each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 memory, 1 I/O, 2/3 refresh |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wide | input | 1 | Request asks for 16 bits |
| req_dma | input | 1 | Request is a DMA transfer |
| req_ready | output | 1 | Idle; a request is accepted |
| done | output | 1 | Last cycle of the request is finishing |
| strap_shared | input | 1 | Low address pins shared with disk data path |
| iocs16_n | input | 1 | Slave I/O 16-bit select, active low |
| mcs16_n | input | 1 | Slave memory 16-bit select, active low |
| iochrdy | input | 1 | Channel ready; low inserts wait states |
| sa | output | 20 | System address |
| la | output | 7 | Latched address bits 23:17 |
| sbhe_n | output | 1 | Byte high enable, active low |
| bale | output | 1 | Address latch strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| smemr_n | output | 1 | Memory read strobe below 1 MB |
| smemw_n | output | 1 | Memory write strobe below 1 MB |
| aen | output | 1 | Address enable during DMA |
| xcvr_oe_n | output | 1 | Address transceiver enable, active low |

## Verification
Wait-state insertion and the split of a 16-bit request into two byte cycles can act on the same request. In that case the stretch of the first half must not lose the pending odd-byte half, and the second half must be stretched in its own right. The bench provokes this by answering a 16-bit memory request with no memory select while a responder holds channel-ready low for several clocks after each strobe falls. The run uses the shared strap, so the transceiver enable is checked across both halves. A scoreboard expects two items, even then odd, each with the stretched length max(CMD_MIN, W+1), and a done count of one for the request.

// File: rtl/isa_cg_pkg.sv
package isa_cg_pkg;

    localparam int ISA_AW = 24;
    localparam int SA_W   = 20;
    localparam int LA_LO  = 17;
    localparam int LA_W   = ISA_AW - LA_LO;

    typedef enum logic [1:0] {
        K_MEM  = 2'd0,
        K_IO   = 2'd1,
        K_RFSH = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_CMD   = 2'd2,
        PH_RECOV = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        kind_e               kind;
        logic                wr;
        logic                dma;
        logic                wide;
        logic                is16;
        logic                split;
        logic [ISA_AW-1:0]   addr;
    } seq_t;

endpackage

// File: rtl/isa_cmd_timer.sv
module isa_cmd_timer #(
    parameter int CMD_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (CMD_MIN > 1) ? $clog2(CMD_MIN) : 1;
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(CMD_MIN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = LOAD_V;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/isa_width_ctl.sv
module isa_width_ctl
    import isa_cg_pkg::*;
(
    input  phase_e ph,
    input  kind_e  kind,
    input  logic   wide,
    input  logic   is16,
    input  logic   addr0,
    input  logic   iocs16_n,
    input  logic   mcs16_n,
    output logic   want16,
    output logic   split,
    output logic   sbhe_n
);
    logic sel_hit;

    always_comb begin
        unique case (kind)
            K_IO:    sel_hit = !iocs16_n;
            K_MEM:   sel_hit = !mcs16_n;
            default: sel_hit = 1'b0;
        endcase
        want16 = wide && sel_hit;
        split  = wide && !sel_hit;
    end

    always_comb begin
        unique case (ph)
            PH_IDLE: sbhe_n = 1'b1;
            PH_ADDR: sbhe_n = !(wide || addr0);
            default: sbhe_n = !(is16 || addr0);
        endcase
        if (kind == K_RFSH) begin
            sbhe_n = 1'b1;
        end
    end

endmodule

// File: rtl/isa_strobe_dec.sv
module isa_strobe_dec
    import isa_cg_pkg::*;
(
    input  phase_e     ph,
    input  kind_e      kind,
    input  logic       wr,
    input  logic [3:0] addr_hi,
    output logic       ior_n,
    output logic       iow_n,
    output logic       memr_n,
    output logic       memw_n,
    output logic       smemr_n,
    output logic       smemw_n
);
    logic cmd_on, rd_mem, wr_mem, low_mb;

    always_comb begin
        cmd_on  = (ph == PH_CMD);
        low_mb  = (addr_hi == 4'h0);
        rd_mem  = cmd_on && ((kind == K_MEM && !wr) || kind == K_RFSH);
        wr_mem  = cmd_on && kind == K_MEM && wr;
        ior_n   = !(cmd_on && kind == K_IO && !wr);
        iow_n   = !(cmd_on && kind == K_IO && wr);
        memr_n  = !rd_mem;
        memw_n  = !wr_mem;
        smemr_n = !(rd_mem && low_mb);
        smemw_n = !(wr_mem && low_mb);
    end

endmodule

// File: rtl/isa_cycle_gen.sv
module isa_cycle_gen
    import isa_cg_pkg::*;
#(
    parameter int CMD_MIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic [ISA_AW-1:0] req_addr,
    input  logic              req_wide,
    input  logic              req_dma,
    output logic              req_ready,
    output logic              done,
    input  logic              strap_shared,
    input  logic              iocs16_n,
    input  logic              mcs16_n,
    input  logic              iochrdy,
    output logic [SA_W-1:0]   sa,
    output logic [LA_W-1:0]   la,
    output logic              sbhe_n,
    output logic              bale,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic              aen,
    output logic              xcvr_oe_n
);
    seq_t  seq_d, seq_q;
    kind_e in_kind;
    logic  t_expired, want16, split_now;

    isa_cmd_timer #(.CMD_MIN(CMD_MIN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seq_q.ph == PH_ADDR),
        .run     (seq_q.ph == PH_CMD),
        .expired (t_expired)
    );

    isa_width_ctl u_width (
        .ph       (seq_q.ph),
        .kind     (seq_q.kind),
        .wide     (seq_q.wide),
        .is16     (seq_q.is16),
        .addr0    (seq_q.addr[0]),
        .iocs16_n (iocs16_n),
        .mcs16_n  (mcs16_n),
        .want16   (want16),
        .split    (split_now),
        .sbhe_n   (sbhe_n)
    );

    isa_strobe_dec u_strobe (
        .ph      (seq_q.ph),
        .kind    (seq_q.kind),
        .wr      (seq_q.wr),
        .addr_hi (seq_q.addr[ISA_AW-1:SA_W]),
        .ior_n   (ior_n),
        .iow_n   (iow_n),
        .memr_n  (memr_n),
        .memw_n  (memw_n),
        .smemr_n (smemr_n),
        .smemw_n (smemw_n)
    );

    always_comb begin
        in_kind = req_kind[1] ? K_RFSH : (req_kind[0] ? K_IO : K_MEM);
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.ph    = PH_ADDR;
                    seq_d.kind  = in_kind;
                    seq_d.wr    = req_write && (in_kind != K_RFSH);
                    seq_d.dma   = req_dma;
                    seq_d.wide  = req_wide && (in_kind != K_RFSH);
                    seq_d.is16  = 1'b0;
                    seq_d.split = 1'b0;
                    seq_d.addr  = seq_d.wide ? {req_addr[ISA_AW-1:1], 1'b0} : req_addr;
                end
            end
            PH_ADDR: begin
                seq_d.ph    = PH_CMD;
                seq_d.is16  = want16;
                seq_d.split = split_now;
            end
            PH_CMD: begin
                if (t_expired && iochrdy) begin
                    seq_d.ph = PH_RECOV;
                end
            end
            default: begin
                if (seq_q.split) begin
                    seq_d.ph      = PH_ADDR;
                    seq_d.addr[0] = 1'b1;
                    seq_d.wide    = 1'b0;
                    seq_d.split   = 1'b0;
                end else begin
                    seq_d.ph = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.ph == PH_IDLE);
    assign done      = (seq_q.ph == PH_RECOV) && !seq_q.split;
    assign bale      = (seq_q.ph == PH_ADDR);
    assign sa        = seq_q.addr[SA_W-1:0];
    assign la        = seq_q.addr[ISA_AW-1:LA_LO];
    assign aen       = seq_q.dma && (seq_q.ph != PH_IDLE);
    assign xcvr_oe_n = !(strap_shared && seq_q.ph != PH_IDLE);

    logic any_cmd;
    assign any_cmd = !(ior_n && iow_n && memr_n && memw_n);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~ior_n, ~iow_n, ~memr_n, ~memw_n}) <= 1); // R3

    AST_SMEM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!smemr_n || !smemw_n) |-> (la[LA_W-1:LA_W-4] == 4'h0 && (!memr_n || !memw_n))); // R4

    AST_BALE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bale |=> (!bale && any_cmd)); // R2

    AST_SA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cmd && $past(any_cmd)) |-> $stable(sa)); // R2

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cmd && !iochrdy) |=> any_cmd); // R6

    AST_RFSH_SBHE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph != PH_IDLE && seq_q.kind == K_RFSH) |-> sbhe_n); // R9

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!any_cmd && !bale && !done)); // R12

endmodule

// File: tb/sim_isa_cycle_gen.sv
`timescale 1ns/1ps
module sim_isa_cycle_gen;

    localparam int CMD_MIN = 4;

    typedef struct {
        logic [19:0] sa;
        logic [6:0]  la;
        int          op;
        logic        smem;
        logic        sbhe_n;
        logic        aen;
        logic        xoe_n;
        int          len;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_wide = 1'b0;
    logic        req_dma = 1'b0;
    logic        strap_shared = 1'b0;
    logic        iocs16_n = 1'b1;
    logic        mcs16_n = 1'b1;
    logic        iochrdy = 1'b1;
    logic        req_ready, done, sbhe_n, bale;
    logic        ior_n, iow_n, memr_n, memw_n, smemr_n, smemw_n, aen, xcvr_oe_n;
    logic [19:0] sa;
    logic [6:0]  la;

    int checks = 0;
    int errors = 0;
    int wait_w = 0;
    int done_cnt = 0;
    int item_cnt = 0;
    int ovl_err = 0;
    int stab_err = 0;
    int aen_err = 0;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    isa_cycle_gen #(.CMD_MIN(CMD_MIN)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .req_addr(req_addr), .req_wide(req_wide),
        .req_dma(req_dma), .req_ready(req_ready), .done(done),
        .strap_shared(strap_shared), .iocs16_n(iocs16_n), .mcs16_n(mcs16_n),
        .iochrdy(iochrdy), .sa(sa), .la(la), .sbhe_n(sbhe_n), .bale(bale),
        .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
        .smemr_n(smemr_n), .smemw_n(smemw_n), .aen(aen), .xcvr_oe_n(xcvr_oe_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic void push(input logic [23:0] a, input int op, input logic sb,
                                 input logic dma, input int len, input string tag);
        exp_t e;
        e.sa = a[19:0];
        e.la = a[23:17];
        e.op = op;
        e.smem = (op <= 1) && (a[23:20] == 4'h0);
        e.sbhe_n = sb;
        e.aen = dma;
        e.xoe_n = !strap_shared;
        e.len = len;
        e.tag = tag;
        expq.push_back(e);
    endfunction

    // scoreboard monitor
    bit          in_cmd = 0;
    int          m_len = 0;
    int          m_op = 0;
    logic        m_smem, m_sbhe, m_aen, m_xoe;
    logic [19:0] cap_sa;
    logic [6:0]  cap_la;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if ($countones({~ior_n, ~iow_n, ~memr_n, ~memw_n}) > 1) ovl_err++;
                if (done) done_cnt++;
                if (bale) begin
                    cap_sa = sa;
                    cap_la = la;
                end
                if (!(ior_n && iow_n && memr_n && memw_n)) begin
                    if (!in_cmd) begin
                        in_cmd = 1;
                        m_len = 0;
                        m_op = !memr_n ? 0 : !memw_n ? 1 : !ior_n ? 2 : 3;
                        m_smem = !smemr_n || !smemw_n;
                        m_sbhe = sbhe_n;
                        m_aen = aen;
                        m_xoe = xcvr_oe_n;
                    end
                    m_len++;
                    if (sa != cap_sa) stab_err++;
                    if (aen != m_aen) aen_err++;
                end else if (in_cmd) begin
                    in_cmd = 0;
                    item_cnt++;
                    if (expq.size() == 0) begin
                        chk(0, "R12", "unexpected cycle", cap_sa, 0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk(cap_sa == e.sa, "R5", {e.tag, " sa"}, cap_sa, e.sa);
                        chk(cap_la == e.la, "R5", {e.tag, " la"}, cap_la, e.la);
                        chk(m_op == e.op, "R3", {e.tag, " strobe"}, m_op, e.op);
                        chk(m_smem == e.smem, "R4", {e.tag, " smem"}, m_smem, e.smem);
                        chk(m_sbhe == e.sbhe_n, "R9", {e.tag, " sbhe_n"}, m_sbhe, e.sbhe_n);
                        chk(m_aen == e.aen, "R10", {e.tag, " aen"}, m_aen, e.aen);
                        chk(aen == e.aen, "R10", {e.tag, " aen in recovery"}, aen, e.aen);
                        chk(m_xoe == e.xoe_n, "R11", {e.tag, " xcvr_oe_n"}, m_xoe, e.xoe_n);
                        chk(m_len == e.len, "R6", {e.tag, " command length"}, m_len, e.len);
                    end
                end
            end
        end
    end

    // channel-ready responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !(ior_n && iow_n && memr_n && memw_n)) begin
                if (wait_w > 0) begin
                    iochrdy = 1'b0;
                    repeat (wait_w) @(negedge clk);
                    iochrdy = 1'b1;
                end
                while (!(ior_n && iow_n && memr_n && memw_n)) @(negedge clk);
            end
        end
    end

    task automatic issue(input logic [1:0] k, input logic w, input logic [23:0] a,
                         input logic wide, input logic dma);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_kind = k;
        req_write = w;
        req_addr = a;
        req_wide = wide;
        req_dma = dma;
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    int exp_len_w;
    int dc0;

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk({ior_n, iow_n, memr_n, memw_n, smemr_n, smemw_n} == 6'h3F, "R1", "strobes in reset",
            {ior_n, iow_n, memr_n, memw_n, smemr_n, smemw_n}, 6'h3F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({bale, aen, done, xcvr_oe_n, req_ready} == 5'b00011, "R1", "idle outputs",
            {bale, aen, done, xcvr_oe_n, req_ready}, 5'b00011);
        chk({ior_n, iow_n, memr_n, memw_n} == 4'hF, "R1", "strobes after reset",
            {ior_n, iow_n, memr_n, memw_n}, 4'hF);

        // R2 R4 R5 8-bit memory read below 1 MB, even address
        push(24'h0A3456, 0, 1'b1, 1'b0, CMD_MIN, "R2 mem rd");
        issue(2'd0, 1'b0, 24'h0A3456, 1'b0, 1'b0);

        // R9 8-bit odd memory write above 1 MB, R4 smem stays high
        push(24'h5A0011, 1, 1'b0, 1'b0, CMD_MIN, "R4 mem wr odd");
        issue(2'd0, 1'b1, 24'h5A0011, 1'b0, 1'b0);

        // R7 16-bit memory write with memory select
        mcs16_n = 1'b0;
        push(24'hC40002, 1, 1'b0, 1'b0, CMD_MIN, "R7 mem16");
        issue(2'd0, 1'b1, 24'hC40003, 1'b1, 1'b0);

        // R8 16-bit I/O read, only memory select low -> split
        push(24'h000300, 2, 1'b1, 1'b0, CMD_MIN, "R8 io split even");
        push(24'h000301, 2, 1'b0, 1'b0, CMD_MIN, "R8 io split odd");
        issue(2'd1, 1'b0, 24'h000300, 1'b1, 1'b0);
        mcs16_n = 1'b1;

        // R7 16-bit I/O write with I/O select
        iocs16_n = 1'b0;
        push(24'h0001F0, 3, 1'b0, 1'b0, CMD_MIN, "R7 io16");
        issue(2'd1, 1'b1, 24'h0001F0, 1'b1, 1'b0);
        iocs16_n = 1'b1;

        // R9 refresh at odd address
        push(24'h0000F1, 0, 1'b1, 1'b0, CMD_MIN, "R9 refresh");
        issue(2'd2, 1'b1, 24'h0000F1, 1'b1, 1'b0);

        // R10 R6 DMA memory read with wait states
        wait_w = 7;
        exp_len_w = (CMD_MIN > wait_w + 1) ? CMD_MIN : wait_w + 1;
        push(24'h012340, 0, 1'b1, 1'b1, exp_len_w, "R10 dma wait");
        issue(2'd0, 1'b0, 24'h012340, 1'b0, 1'b1);
        wait_w = 0;

        // R11 R8 R6 shared strap, split with wait states on both halves
        strap_shared = 1'b1;
        @(negedge clk);
        chk(xcvr_oe_n == 1'b1, "R11", "shared idle xcvr", xcvr_oe_n, 1);
        wait_w = 5;
        exp_len_w = (CMD_MIN > wait_w + 1) ? CMD_MIN : wait_w + 1;
        dc0 = done_cnt;
        push(24'h0E8000, 0, 1'b1, 1'b0, exp_len_w, "R11 split even");
        push(24'h0E8001, 0, 1'b0, 1'b0, exp_len_w, "R11 split odd");
        issue(2'd0, 1'b0, 24'h0E8000, 1'b1, 1'b0);
        wait_w = 0;
        chk(done_cnt - dc0 == 1, "R12", "one done per split request", done_cnt - dc0, 1);
        chk(xcvr_oe_n == 1'b1, "R11", "shared after cycle", xcvr_oe_n, 1);
        strap_shared = 1'b0;

        // R12 request while busy is ignored
        push(24'h000040, 2, 1'b1, 1'b0, CMD_MIN, "R12 busy");
        @(negedge clk);
        req_kind = 2'd1; req_write = 1'b0; req_addr = 24'h000040;
        req_wide = 1'b0; req_dma = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R12", "ready while busy", req_ready, 0);
        req_addr = 24'h0F0F0E; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (2 * CMD_MIN + 6) @(negedge clk);

        chk(expq.size() == 0, "R12", "scoreboard drained", expq.size(), 0);
        chk(item_cnt == 11, "R12", "cycle count", item_cnt, 11);
        chk(done_cnt == 9, "R12", "done count", done_cnt, 9);
        chk(ovl_err == 0, "R3", "strobe overlap clocks", ovl_err, 0);
        chk(stab_err == 0, "R2", "address change during command", stab_err, 0);
        chk(aen_err == 0, "R10", "aen change during command", aen_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule